// File: doc/BRIEF.md
# Fan Fault Monitor with Wake Interrupt

This block supervises a small group of cooling fans. For every fan it receives four values from neighbouring logic: the measured tachometer count (a period count, so a larger value means a slower fan), a count ceiling, a target count and the PWM duty currently driven. From these it derives two kinds of fault. A sticky status bit latches whenever the measured count goes above the ceiling. A live exception flag reports either a fan that has been slower than its target for longer than a programmable window, or a fan that sits stopped while it is being driven.

Software reaches the block through a byte-wide register bus with separate write and read strobes. There are four registers: per-fan wake enables, the sticky status (write one to clear), the live exception view (read only) and the slow-fan window length. Any enabled status bit pulls a single active-low wake/interrupt line.

Both timers count a 1 kHz tick input. The slow-fan window counts in units of `TICKS_PER_UNIT` ticks (100 by default, giving 100 ms). The stall window is `STALL_TICKS` ticks (3000 by default, giving 3 s).

Top module: `fanmon_top`

## Requirements
- R1: After reset the enable, status, exception and window registers read 0, `bus_rdata_o` is 0 and `wake_n_o` is 1.
- R2: In the enable (0x90), status (0x91) and exception (0x92) registers, bit i belongs to fan i+1 (fan input slice i). Bits at position `NF` and above read as 0. The enable register is read/write.
- R3: A fan's status bit is set on the clock edge at which its tachometer count is strictly greater than its count limit. It then stays set after the count falls back.
- R4: Writing 1 to a status bit at 0x91 clears it. Writing 0 leaves it unchanged.
- R5: If a status bit is written with 1 in a cycle in which its over-limit condition is present, the bit stays set.
- R6: `wake_n_o` is 0 exactly while some fan has both its status bit and its enable bit set. It returns to 1 once no such fan remains.
- R7: A fan's exception bit becomes 1 once its count has stayed strictly above its expected count through `T` unit periods, where `T` is the non-zero value at 0x9F. It drops to 0 as soon as the count is no longer above the expected count.
- R8: When 0x9F holds 0, a count above the expected count never raises the exception bit.
- R9: A fan whose count is all ones (stopped) and whose duty is non-zero raises its exception bit after `STALL_TICKS` ticks. The stall timer restarts when the count leaves all ones or the duty becomes 0.
- R10: Writes to 0x92 have no effect. Register 0x9F holds a full 8-bit value that reads back as written.
- R11: Read data appears on `bus_rdata_o` one cycle after the read strobe and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1khz_i | input | 1 | One-cycle pulse at 1 kHz that drives both timers |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_rdata_o | output | 8 | Read data, registered |
| tach_cnt_i | input | NF*CW | Measured tachometer count per fan, fan 1 in the low slice |
| cnt_limit_i | input | NF*CW | Count limit per fan for the sticky status |
| exp_cnt_i | input | NF*CW | Expected count per fan for the exception timer |
| duty_i | input | NF*DW | Applied PWM duty per fan |
| wake_n_o | output | 1 | Active-low wake/interrupt request |

## Verification
On every cycle the assertions check several properties. Over-limit always sets status on the next edge, even against a clear. A status bit falls only after a write of one to it. A low wake line always has a status bit behind it. Reserved read bits are zero, and read data holds between strobes. The timed behaviour of the exception flag can only be shown by the bench scenarios. That covers the exact tick on which the slow-fan and stall windows expire, the disable value of the window register, and the two ways of restarting the stall timer. The bench scenarios also cover the enable/status combinations on the wake line.

// File: rtl/fanmon_pkg.sv
package fanmon_pkg;

    localparam logic [7:0] ADDR_EN  = 8'h90;
    localparam logic [7:0] ADDR_STS = 8'h91;
    localparam logic [7:0] ADDR_RT  = 8'h92;
    localparam logic [7:0] ADDR_TMO = 8'h9F;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN,
        SEL_STS,
        SEL_RT,
        SEL_TMO
    } reg_sel_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] wdata;
        logic       wr;
        logic       rd;
    } bus_req_t;

    function automatic reg_sel_t decode_addr(input logic [7:0] a);
        case (a)
            ADDR_EN:  return SEL_EN;
            ADDR_STS: return SEL_STS;
            ADDR_RT:  return SEL_RT;
            ADDR_TMO: return SEL_TMO;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fanmon_prescale.sv
module fanmon_prescale #(
    parameter int TICKS_PER_UNIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic unit_o
);
    localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_UNIT - 1);

    logic [PW-1:0] pcnt_q;

    assign unit_o = tick_i && (pcnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (tick_i) begin
            pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fanmon_chan.sv
module fanmon_chan #(
    parameter int CW          = 8,
    parameter int DW          = 8,
    parameter int STALL_TICKS = 3000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          unit_i,
    input  logic [CW-1:0] tach_i,
    input  logic [CW-1:0] limit_i,
    input  logic [CW-1:0] expc_i,
    input  logic [DW-1:0] duty_i,
    input  logic [7:0]    tmo_i,
    output logic          over_o,
    output logic          exc_o
);
    localparam int SW = $clog2(STALL_TICKS + 1);
    localparam logic [SW-1:0] STALL_END = SW'(STALL_TICKS);

    logic          miss;
    logic          stalled;
    logic [7:0]    mcnt_q;
    logic [SW-1:0] scnt_q;

    assign over_o  = tach_i > limit_i;
    assign miss    = tach_i > expc_i;
    assign stalled = (tach_i == {CW{1'b1}}) && (duty_i != '0);

    always_ff @(posedge clk) begin
        if (rst || !miss) begin
            mcnt_q <= '0;
        end else if (unit_i && mcnt_q != 8'hFF) begin
            mcnt_q <= mcnt_q + 8'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !stalled) begin
            scnt_q <= '0;
        end else if (tick_i && scnt_q != STALL_END) begin
            scnt_q <= scnt_q + 1'b1;
        end
    end

    assign exc_o = (miss && tmo_i != 8'd0 && mcnt_q >= tmo_i)
                 || (stalled && scnt_q == STALL_END);
endmodule

// File: rtl/fanmon_regs.sv
module fanmon_regs
    import fanmon_pkg::*;
#(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req_i,
    input  logic [NF-1:0] over_i,
    input  logic [NF-1:0] rt_i,
    output logic [NF-1:0] en_o,
    output logic [NF-1:0] sts_o,
    output logic [7:0]    tmo_o,
    output logic [7:0]    rdata_o
);
    reg_sel_t      sel;
    logic [NF-1:0] clr;
    logic [7:0]    rd_mux;

    assign sel = decode_addr(req_i.addr);
    assign clr = (req_i.wr && sel == SEL_STS) ? req_i.wdata[NF-1:0] : '0;

    always_comb begin
        case (sel)
            SEL_EN:  rd_mux = 8'(en_o);
            SEL_STS: rd_mux = 8'(sts_o);
            SEL_RT:  rd_mux = 8'(rt_i);
            SEL_TMO: rd_mux = tmo_o;
            default: rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o    <= '0;
            sts_o   <= '0;
            tmo_o   <= '0;
            rdata_o <= '0;
        end else begin
            if (req_i.wr && sel == SEL_EN)  en_o  <= req_i.wdata[NF-1:0];
            if (req_i.wr && sel == SEL_TMO) tmo_o <= req_i.wdata;
            sts_o <= (sts_o & ~clr) | over_i;
            if (req_i.rd) rdata_o <= rd_mux;
        end
    end
endmodule

// File: rtl/fanmon_top.sv
module fanmon_top
    import fanmon_pkg::*;
#(
    parameter int NF             = 3,
    parameter int CW             = 8,
    parameter int DW             = 8,
    parameter int TICKS_PER_UNIT = 100,
    parameter int STALL_TICKS    = 3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1khz_i,
    input  logic [7:0]       bus_addr_i,
    input  logic [7:0]       bus_wdata_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    output logic [7:0]       bus_rdata_o,
    input  logic [NF*CW-1:0] tach_cnt_i,
    input  logic [NF*CW-1:0] cnt_limit_i,
    input  logic [NF*CW-1:0] exp_cnt_i,
    input  logic [NF*DW-1:0] duty_i,
    output logic             wake_n_o
);
    bus_req_t      req;
    logic          unit_w;
    logic [NF-1:0] over_w;
    logic [NF-1:0] rt_w;
    logic [NF-1:0] en_w;
    logic [NF-1:0] sts_w;
    logic [7:0]    tmo_w;

    assign req = '{addr: bus_addr_i, wdata: bus_wdata_i, wr: bus_wr_i, rd: bus_rd_i};

    fanmon_prescale #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_1khz_i),
        .unit_o (unit_w)
    );

    for (genvar i = 0; i < NF; i++) begin : g_fan
        fanmon_chan #(.CW(CW), .DW(DW), .STALL_TICKS(STALL_TICKS)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick_i  (tick_1khz_i),
            .unit_i  (unit_w),
            .tach_i  (tach_cnt_i[i*CW +: CW]),
            .limit_i (cnt_limit_i[i*CW +: CW]),
            .expc_i  (exp_cnt_i[i*CW +: CW]),
            .duty_i  (duty_i[i*DW +: DW]),
            .tmo_i   (tmo_w),
            .over_o  (over_w[i]),
            .exc_o   (rt_w[i])
        );
    end

    fanmon_regs #(.NF(NF)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .over_i  (over_w),
        .rt_i    (rt_w),
        .en_o    (en_w),
        .sts_o   (sts_w),
        .tmo_o   (tmo_w),
        .rdata_o (bus_rdata_o)
    );

    assign wake_n_o = ~|(sts_w & en_w);
endmodule

// File: rtl/fanmon_chk.sv
module fanmon_chk
    import fanmon_pkg::*;
#(
    parameter int NF = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [7:0]    bus_addr_i,
    input logic [7:0]    bus_wdata_i,
    input logic          bus_wr_i,
    input logic          bus_rd_i,
    input logic [7:0]    bus_rdata_o,
    input logic [NF-1:0] over,
    input logic [NF-1:0] sts,
    input logic          wake_n_o
);
    localparam logic [7:0] HI_MASK = ~8'((1 << NF) - 1);

    logic [NF-1:0] clr_req;
    logic          bank_rd;

    assign clr_req = (bus_wr_i && bus_addr_i == ADDR_STS) ? bus_wdata_i[NF-1:0] : '0;
    assign bank_rd = bus_rd_i && (bus_addr_i == ADDR_EN || bus_addr_i == ADDR_STS
                                  || bus_addr_i == ADDR_RT);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bank_rd) |-> ((bus_rdata_o & HI_MASK) == 8'h00));

    // R3 R5
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (over != '0) |=> ((sts & $past(over)) == $past(over)));

    // R4
    sticky_until_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(sts) & ~$past(clr_req)) & ~sts) == '0));

    // R6
    wake_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        !wake_n_o |-> (sts != '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd_i) |-> $stable(bus_rdata_o));
endmodule

bind fanmon_top fanmon_chk #(.NF(NF)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_rdata_o (bus_rdata_o),
    .over        (over_w),
    .sts         (sts_w),
    .wake_n_o    (wake_n_o)
);

// File: tb/fanmon_top_bench.sv
module fanmon_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NF  = 3;
    localparam int CW  = 4;
    localparam int DW  = 4;
    localparam int TPU = 4;
    localparam int STL = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [7:0] addr = '0, wdata = '0, rdata;
    logic wr_stb = 1'b0, rd_stb = 1'b0;
    logic wake_n;
    logic [CW-1:0] tach [NF];
    logic [CW-1:0] lim  [NF];
    logic [CW-1:0] expc [NF];
    logic [DW-1:0] duty [NF];
    int n_chk = 0, n_fail = 0, phase = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fanmon_top #(.NF(NF), .CW(CW), .DW(DW), .TICKS_PER_UNIT(TPU), .STALL_TICKS(STL)) u_fanmon_top (
        .clk (clk), .rst (rst), .tick_1khz_i (tick),
        .bus_addr_i (addr), .bus_wdata_i (wdata), .bus_wr_i (wr_stb), .bus_rd_i (rd_stb),
        .bus_rdata_o (rdata),
        .tach_cnt_i  ({tach[2], tach[1], tach[0]}),
        .cnt_limit_i ({lim[2], lim[1], lim[0]}),
        .exp_cnt_i   ({expc[2], expc[1], expc[0]}),
        .duty_i      ({duty[2], duty[1], duty[0]}),
        .wake_n_o (wake_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0; d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            phase = (phase + 1) % TPU;
        end
    endtask

    task automatic align();
        while (phase != 0) ticks(1);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < NF; i++) begin
            tach[i] = '0; lim[i] = 4'hF; expc[i] = 4'hF; duty[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        chk("R1 rdata", rdata, 0);
        chk("R1 wake_n", wake_n, 1);
        rd(8'h90, d); chk("R1 enable", d, 0);
        rd(8'h91, d); chk("R1 status", d, 0);
        rd(8'h92, d); chk("R1 exception", d, 0);
        rd(8'h9F, d); chk("R1 window", d, 0);

        // R2 enable read/write, reserved bits zero
        wr(8'h90, 8'hFF); rd(8'h90, d); chk("R2 enable masked", d, 8'h07);
        wr(8'h90, 8'h05); rd(8'h90, d); chk("R2 enable readback", d, 8'h05);
        wr(8'h90, 8'h00);

        // R3 R4 R2 sweep of count against limit for every fan
        for (int f = 0; f < NF; f++) begin
            lim[f] = 4'd7;
            for (int t = 0; t < 16; t++) begin
                @(negedge clk); tach[f] = 4'(t);
                @(negedge clk); tach[f] = '0;
                rd(8'h91, d); chk("R3 status set/bitmap", d, (t > 7) ? (1 << f) : 0);
                wr(8'h91, 8'hFF);
                rd(8'h91, d); chk("R4 write-one clears", d, 0);
            end
            lim[f] = 4'hF;
        end

        // R4 writing 0 leaves the bit; R5 set beats clear
        @(negedge clk); lim[1] = 4'd3; tach[1] = 4'd9;
        @(negedge clk); tach[1] = '0;
        wr(8'h91, 8'h00); rd(8'h91, d); chk("R4 write zero ignored", d, 8'h02);
        wr(8'h91, 8'hFD); rd(8'h91, d); chk("R4 other bits no effect", d, 8'h02);
        @(negedge clk); tach[1] = 4'd9;
        wr(8'h91, 8'h02); rd(8'h91, d); chk("R5 set wins over clear", d, 8'h02);
        @(negedge clk); tach[1] = '0;

        // R6 wake line over all enable patterns, status on fan 2 only
        for (int e = 0; e < 8; e++) begin
            wr(8'h90, 8'(e));
            @(negedge clk); chk("R6 wake_n vs enable", wake_n, ((e >> 1) & 1) ? 0 : 1);
        end
        wr(8'h91, 8'h02);
        @(negedge clk); chk("R6 wake_n released", wake_n, 1);
        wr(8'h90, 8'h00); lim[1] = 4'hF;

        // R10 exception register read-only, window full width
        wr(8'h92, 8'hFF); rd(8'h92, d); chk("R10 exception read-only", d, 0);
        wr(8'h9F, 8'hA5); rd(8'h9F, d); chk("R10 window readback", d, 8'hA5);
        // R11 unmapped reads zero, data holds
        rd(8'h55, d); chk("R11 unmapped", d, 0);
        rd(8'h9F, d);
        repeat (4) @(negedge clk);
        chk("R11 rdata holds", rdata, 8'hA5);

        // R7 slow-fan window of 2 units on fan 1
        wr(8'h9F, 8'h02);
        align();
        @(negedge clk); expc[0] = 4'd5; tach[0] = 4'd6;
        ticks(2 * TPU - 1);
        rd(8'h92, d); chk("R7 before window", d, 0);
        ticks(1);
        rd(8'h92, d); chk("R7 window expired", d, 8'h01);
        @(negedge clk); tach[0] = 4'd5;
        rd(8'h92, d); chk("R7 clears at once", d, 0);

        // R8 window value 0 disables
        wr(8'h9F, 8'h00);
        @(negedge clk); tach[0] = 4'd9;
        ticks(6 * TPU);
        rd(8'h92, d); chk("R8 disabled window", d, 0);
        @(negedge clk); tach[0] = '0; expc[0] = 4'hF;

        // R9 stall on fan 3
        @(negedge clk); tach[2] = 4'hF; duty[2] = 4'd3;
        ticks(STL - 1);
        rd(8'h92, d); chk("R9 before stall", d, 0);
        ticks(1);
        rd(8'h92, d); chk("R9 stall raised", d, 8'h04);
        @(negedge clk); duty[2] = '0;
        rd(8'h92, d); chk("R9 duty zero clears", d, 0);
        @(negedge clk); duty[2] = 4'd3;
        ticks(STL - 1);
        rd(8'h92, d); chk("R9 restart after duty zero", d, 0);
        @(negedge clk); tach[2] = 4'd8;
        @(negedge clk); tach[2] = 4'hF;
        ticks(STL - 1);
        rd(8'h92, d); chk("R9 restart after rotation", d, 0);
        ticks(1);
        rd(8'h92, d); chk("R9 stall after restart", d, 8'h04);

        done = 1'b1;
        summary();
    end
endmodule